// File: doc/BRIEF.md
# Clock Generator Configuration I2C Slave

This block is an I2C slave that holds the configuration bytes of a clock generator: frequency selection, spreading mode and per-output enables. The SCL and SDA lines are sampled by a much faster system clock. Each line passes through a two-flop synchronizer and a glitch filter before start, stop and bit edges are detected. SDA is open-drain: the block only drives it low. SCL is an input only, because the slave never stretches the clock.

Writes always use a block format. After the write address, the master sends a command byte and a byte count. The slave acknowledges both and throws both away. The data bytes that follow fill register 0 upward, one register per byte, and a stop may end the transfer after any whole byte. A read sends a count byte first and then every register from 0 upward. The register bank's outputs are parallel, registered, and drive the rest of the clock logic directly.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x00, registers 1 to 5 hold 0xFF and SDA is released. Register k appears on `cfg_o[8k+7:8k]`.
- R2: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), which are 7-bit address 0x69 plus the R/W bit sent last. Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R3: In a write, the first two bytes after the address (command and count) are acknowledged and leave every register unchanged. Data bytes go to register 0, then 1, and so on up to 5. Each data byte is acknowledged.
- R4: A stop after any whole data byte keeps the registers already written and leaves the others unchanged.
- R5: Write data bytes beyond register 5 are acknowledged and discarded.
- R6: In a read, the slave sends the count 0x06 and then registers 0 to 5, MSB first. SDA changes only while SCL is low.
- R7: A master NACK ends slave transmission. SDA stays released until the next start, so further clocked bits read as 1.
- R8: A repeated start resets the byte position. A following read begins with the count byte, and a following write begins again at register 0.
- R9: SCL or SDA pulses shorter than the filter length (3 system clocks by default) are ignored. Transfers that contain such pulses complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | 48 | Register contents, register k in bits [8k+7:8k] |

## Verification
The bench checks the following cases and the failure each would show:
- Command and count bytes: a slave that stored them would shift every later register by two.
- Truncated writes: a slave that cleared or advanced unwritten registers would fail here.
- Overflow writes: a slave with a pointer that wraps would overwrite register 0.
- Master NACK during a read: a slave that kept driving would pull SDA low on the next clocked bits.
- Repeated start: a slave that did not clear the pointer would return data where the count byte belongs.
- Short pulses on both lines: without filtering they would add a bit to a byte or fake a start or stop, and the register value would be corrupted.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;
endpackage

// File: rtl/cfgi2c_deglitch.sv
module cfgi2c_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (run_q == LAST) begin
          line_o <= sync_q[1];
          run_q  <= '0;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = {{(NUM_REGS-1){8'hFF}}, 8'h00},
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_o[k*8 +: 8] <= RESET_VAL[k*8 +: 8];
      end else if (wr_en && (wr_idx == IDX_W'(k))) begin
        regs_o[k*8 +: 8] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cfgi2c_engine.sv
module cfgi2c_engine
  import cfgi2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int PTR_W = $clog2(NUM_REGS + 3)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_f,
  input  logic                  sda_f,
  input  logic [NUM_REGS*8-1:0] regs_i,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [7:0]            wr_data,
  output logic                  sda_oe
);
  localparam logic [PTR_W-1:0] FIRST_DATA = PTR_W'(2);
  localparam logic [PTR_W-1:0] END_DATA   = PTR_W'(NUM_REGS + 2);
  localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

  phase_t           phase;
  logic             scl_d, sda_d;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] byte_idx;
  logic             is_addr, rd_mode, byte_full, got_ack;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]       tx_byte;
  logic [PTR_W-1:0] data_off;

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
  assign data_off = byte_idx - FIRST_DATA;

  // byte to send: count first, then registers, then all ones
  always_comb begin
    tx_byte = 8'hFF;
    if (byte_idx == '0) tx_byte = COUNT_BYTE;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (byte_idx == PTR_W'(k + 1)) tx_byte = regs_i[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_idx  <= '0;
      is_addr   <= 1'b0;
      rd_mode   <= 1'b0;
      byte_full <= 1'b0;
      got_ack   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_en <= 1'b0;
      if (start_c) begin
        phase     <= PH_RX;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        is_addr   <= 1'b1;
        rd_mode   <= 1'b0;
        byte_idx  <= '0;
        sda_oe    <= 1'b0;
      end else if (stop_c) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise) begin
              shreg     <= {shreg[6:0], sda_f};
              bit_cnt   <= bit_cnt + 3'd1;
              byte_full <= (bit_cnt == 3'd7);
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              if (is_addr) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  phase   <= PH_RX_ACK;
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                phase  <= PH_RX_ACK;
                sda_oe <= 1'b1;
                if (byte_idx >= FIRST_DATA && byte_idx < END_DATA) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= data_off[IDX_W-1:0];
                  wr_data <= shreg;
                end
                if (byte_idx != '1) byte_idx <= byte_idx + PTR_W'(1);
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              bit_cnt <= '0;
              if (is_addr && rd_mode) begin
                phase  <= PH_TX;
                shreg  <= tx_byte;
                sda_oe <= ~tx_byte[7];
              end else begin
                phase  <= PH_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                phase  <= PH_TX_ACK;
                sda_oe <= 1'b0;
                if (byte_idx != '1) byte_idx <= byte_idx + PTR_W'(1);
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_oe  <= ~shreg[6];
                bit_cnt <= bit_cnt + 3'd1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              got_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (got_ack) begin
                phase   <= PH_TX;
                shreg   <= tx_byte;
                sda_oe  <= ~tx_byte[7];
                bit_cnt <= '0;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int FILT_LEN = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = {{(NUM_REGS-1){8'hFF}}, 8'h00}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             scl_filt, sda_filt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfgi2c_deglitch #(.FILT_LEN(FILT_LEN)) u_scl_flt (
    .clk(clk), .rst(rst), .line_i(scl_i), .line_o(scl_filt)
  );

  cfgi2c_deglitch #(.FILT_LEN(FILT_LEN)) u_sda_flt (
    .clk(clk), .rst(rst), .line_i(sda_i), .line_o(sda_filt)
  );

  cfgi2c_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst(rst), .scl_f(scl_filt), .sda_f(sda_filt),
    .regs_i(cfg_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_drive_low_o)
  );

  cfgi2c_regbank #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(cfg_o)
  );
endmodule

// File: rtl/clkcfg_i2c_checker.sv
module clkcfg_i2c_checker #(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = {{(NUM_REGS-1){8'hFF}}, 8'h00}
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_f,
  input logic                  scl_sync,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg
);
  logic [NUM_REGS*8-1:0] prev_cfg;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk) prev_cfg <= cfg;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chg
    assign chg[k] = (cfg[k*8 +: 8] != prev_cfg[k*8 +: 8]);
  end

  // R1: defaults and released SDA on the first cycle after reset
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg == RESET_VAL) && !sda_oe);

  // R3: one stored byte goes to a single register
  a_r3_single_reg_update: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $countones(chg) <= 1);

  // R6: the slave moves SDA only while the filtered SCL is low
  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  // R7: a stop leaves SDA released
  a_r7_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R9: filtered SCL rises only after the synchronized line stayed high
  a_r9_filter_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_f) |-> $past(scl_sync) && $past(scl_sync, 2));
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_filt), .scl_sync(u_scl_flt.sync_q[1]),
  .stop_det(u_engine.stop_c), .sda_oe(sda_drive_low_o), .cfg(cfg_o)
);

// File: tb/clkcfg_i2c_slave_tb_top.sv
module clkcfg_i2c_slave_tb_top;
  localparam int Q  = 10;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic drv;
  logic [47:0] cfg;
  wire  sda_bus = sda_m & ~drv;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [6];
  logic [7:0] wbuf [10];

  always #5 clk = ~clk;

  clkcfg_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_low_o(drv), .cfg_o(cfg)
  );

  function automatic logic [47:0] model_vec();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    wq();
    sda_m = b;
    if (glitch) begin
      repeat (3) @(negedge clk);
      scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
      repeat (Q - 4) @(negedge clk);
    end else wq();
    scl_m = 1'b1;
    if (glitch) begin
      repeat (4) @(negedge clk);
      sda_m = ~b; @(negedge clk); sda_m = b;
      repeat (Q - 5) @(negedge clk);
    end else wq();
    wq();
    scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic r);
    sda_m = 1'b1; wq(); wq();
    scl_m = 1'b1; wq();
    r = sda_bus; wq();
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(d[i], glitch);
    bit_in(r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_in(r);
      d[i] = r;
    end
    bit_out(!mack, 1'b0);
  endtask

  // block write: address, command, count, n data bytes
  task automatic do_write(input int n, input bit do_stop, input bit glitch);
    bit ack;
    i2c_start();
    send_byte(8'hD2, 1'b0, ack);
    check(ack, "R2 write address ack", 48'(ack), 48'd1);
    send_byte(8'($urandom), 1'b0, ack);
    check(ack, "R3 command byte ack", 48'(ack), 48'd1);
    send_byte(8'($urandom), 1'b0, ack);
    check(ack, "R3 count byte ack", 48'(ack), 48'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], glitch, ack);
      if (i < 6) begin
        model[i] = wbuf[i];
        check(ack, "R3 data byte ack", 48'(ack), 48'd1);
      end else begin
        check(ack, "R5 extra data byte ack", 48'(ack), 48'd1);
      end
    end
    if (do_stop) i2c_stop();
  endtask

  // read after a start or repeated start already issued
  task automatic read_body(input string tag);
    bit ack;
    logic [7:0] d;
    send_byte(8'hD3, 1'b0, ack);
    check(ack, "R2 read address ack", 48'(ack), 48'd1);
    recv_byte(1'b1, d);
    check(d == 8'h06, {tag, " count byte"}, 48'(d), 48'h06);
    for (int k = 0; k < 6; k++) begin
      recv_byte(k < 5, d);
      check(d == model[k], {tag, " register byte"}, 48'(d), 48'(model[k]));
    end
    i2c_stop();
  endtask

  task automatic check_regs(input string tag);
    @(negedge clk);
    check(cfg == model_vec(), tag, cfg, model_vec());
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    logic r;
    logic [7:0] d;
    int n;
    void'($urandom(32'h5EED_1234));
    model[0] = 8'h00;
    for (int k = 1; k < 6; k++) model[k] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(cfg == model_vec(), "R1 reset register values", cfg, model_vec());
    check(drv == 1'b0, "R1 SDA released after reset", 48'(drv), 48'd0);

    // full six-register write, then read back
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h11 * 8'(i + 1) ^ 8'h80;
    do_write(6, 1'b1, 1'b0);
    check_regs("R3 full write contents");
    i2c_start();
    read_body("R6");

    // truncated write of two bytes
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    do_write(2, 1'b1, 1'b0);
    check_regs("R4 truncated write keeps rest");

    // overflow write of eight bytes
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h5A + 8'(i * 7));
    do_write(8, 1'b1, 1'b0);
    check_regs("R5 overflow bytes discarded");

    // foreign address
    i2c_start();
    send_byte(8'hA0, 1'b0, ack);
    check(!ack, "R2 foreign address not acked", 48'(ack), 48'd0);
    send_byte(8'h00, 1'b0, ack);
    check(!ack, "R2 ignored after foreign address", 48'(ack), 48'd0);
    i2c_stop();
    check_regs("R2 foreign address leaves registers");
    i2c_start();
    send_byte(8'hD0, 1'b0, ack);
    check(!ack, "R2 near address not acked", 48'(ack), 48'd0);
    i2c_stop();

    // master NACK after the count byte
    i2c_start();
    send_byte(8'hD3, 1'b0, ack);
    recv_byte(1'b0, d);
    check(d == 8'h06, "R7 count before nack", 48'(d), 48'h06);
    d = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      bit_in(r);
      d[i] = r;
    end
    check(d == 8'hFF, "R7 bus released after nack", 48'(d), 48'hFF);
    i2c_stop();
    check(drv == 1'b0, "R7 no drive after stop", 48'(drv), 48'd0);

    // repeated start: write two bytes, then read from the start
    wbuf[0] = 8'h96; wbuf[1] = 8'h69;
    do_write(2, 1'b0, 1'b0);
    i2c_rstart();
    read_body("R8");
    // repeated start between writes restarts at register 0
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    do_write(3, 1'b0, 1'b0);
    i2c_rstart();
    send_byte(8'hD2, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'hE7, 1'b0, ack);
    model[0] = 8'hE7;
    check(ack, "R8 data ack after restart", 48'(ack), 48'd1);
    i2c_stop();
    check_regs("R8 write restarts at register 0");

    // short pulses on both lines during data bytes
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h0F;
    do_write(3, 1'b1, 1'b1);
    check_regs("R9 glitches ignored");

    // random block writes, each read back
    for (int t = 0; t < 10; t++) begin
      n = int'($urandom_range(0, 7));
      for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
      do_write(n, 1'b1, 1'b0);
      check_regs("R3 random write contents");
      if (t % 3 == 0) begin
        i2c_start();
        read_body("R6 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule